// File: doc/BRIEF.md
# Configuration Window Decoder for an Express Host Bridge

This block gives a host a memory-mapped path into the configuration spaces of the functions below an express host bridge. Each 32-bit host read or write is compared against a window whose base can be moved at run time and whose size is a power of two. The offset into the window is split into a bus number, a device number, a function number and a register offset. A small table of attached functions then decides where the access goes.

An access that lands on a table entry within that function's configuration-space size is forwarded on a function-side port. Register storage is not part of this block. A read that finds no function, or asks for an offset past the function's limit, returns all ones. A write in the same situation is dropped.

Software moves or disables the window through a control port. Every update first removes the current mapping. The window is only put back at the new base when the request is enabled and legal.

Top module: `cfg_window_decoder`

## Requirements
- R1: Out of reset the window is unmapped (`win_mapped`=0), the attached-function table is empty, and every host request is answered with `miss_valid` and never with `rsp_valid`.
- R2: A pulse on `ctl_update` always removes the current mapping. When `ctl_enable` is 0 the window stays unmapped and `ctl_reject` stays 0. The old base stops decoding in either case.
- R3: When `ctl_update` is pulsed with `ctl_enable`=1, the window is mapped only if all three conditions hold: `ctl_size` is a power of two, it lies between 2^20 and 2^28 bytes inclusive, and `ctl_base` is a multiple of `ctl_size`. Otherwise `ctl_reject` is 1 for one cycle and `win_mapped` stays 0. Both outputs are valid the cycle after the update.
- R4: A request hits when the window is mapped and base <= addr < base+size. A hit gives `rsp_valid` one cycle later. Any other request gives `miss_valid` one cycle later instead.
- R5: In a hit, the window offset is split as follows: bits 11:0 are the register offset, bits 14:12 the function, bits 19:15 the device, and bits 28:20 the bus. Offset bits at or above the window size read as zero. A routed access presents the offset with bits 1:0 cleared on `fn_off`.
- R6: The table holds 8 entries. Each entry has a valid bit, a 17-bit tag {bus[8:0], device[4:0], function[2:0]} and an express flag (1 = 4096-byte space, 0 = 256-byte space). Entries are written through `tbl_wr`/`tbl_idx`. A hit is routed to the lowest-numbered valid entry whose tag matches, and that entry's index is driven on `fn_sel`.
- R7: A hit with no matching valid entry returns 0xFFFFFFFF on a read. On a write, `fn_wr_en` stays 0.
- R8: For a conventional entry, a register offset of 0x100 or more reads 0xFFFFFFFF and a write to it is dropped. An express entry accepts every offset up to 0xFFC.
- R9: On a routed write, `fn_be` carries `req_be` so that bytes not enabled are left unchanged. On a routed read, each byte lane whose `req_be` bit is 0 returns 0xFF.
- R10: Exactly one of `rsp_valid` and `miss_valid` is asserted in the cycle after each request, and neither is asserted without a request. `fn_rd_en`/`fn_wr_en` are asserted combinationally in the request cycle, and `fn_rdata` is sampled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_update | input | 1 | Pulse: remove the current mapping and, if enabled and legal, map again |
| ctl_enable | input | 1 | Map after the update |
| ctl_base | input | 32 | New window base |
| ctl_size | input | 32 | New window size in bytes |
| win_mapped | output | 1 | Window is currently decoding |
| ctl_reject | output | 1 | One-cycle flag: the last enabled update was illegal |
| tbl_wr | input | 1 | Write one table entry |
| tbl_idx | input | 3 | Entry index |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_tag | input | 17 | {bus, device, function} tag |
| tbl_express | input | 1 | 1 = 4096-byte space, 0 = 256-byte space |
| req_valid | input | 1 | Host request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Window hit answered |
| rsp_rdata | output | 32 | Read data (all ones for writes and unrouted reads) |
| miss_valid | output | 1 | Request fell outside the window |
| fn_rd_en | output | 1 | Routed read strobe |
| fn_wr_en | output | 1 | Routed write strobe |
| fn_sel | output | 3 | Selected table entry |
| fn_off | output | 12 | Dword-aligned register offset |
| fn_be | output | 4 | Byte enables for the function |
| fn_wdata | output | 32 | Write data for the function |
| fn_rdata | input | 32 | Read data from the selected function, same cycle |

## Verification
The in-module properties assume that reset is held low before the first clock edge. They also assume that `req_valid`, `ctl_update` and `tbl_wr` are never unknown once reset is released, and that the function side returns `fn_rdata` in the same cycle as the strobe.

The bench drives every input on the falling clock edge and holds each request for exactly one cycle. It keeps requests and control updates in separate cycles, and it backs the function port with a memory that always answers in the same cycle. The stimulus therefore stays inside these assumptions.

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NUM_FN    = 8,
  parameter int MIN_LOG2  = 20,
  parameter int MAX_LOG2  = 28,
  parameter int BUS_W     = 9,
  localparam int IDX_W    = $clog2(NUM_FN),
  localparam int TAG_W    = BUS_W + 8,
  localparam int NB       = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_update,
  input  logic             ctl_enable,
  input  logic [AW-1:0]    ctl_base,
  input  logic [AW-1:0]    ctl_size,
  output logic             win_mapped,
  output logic             ctl_reject,
  input  logic             tbl_wr,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic             tbl_valid,
  input  logic [TAG_W-1:0] tbl_tag,
  input  logic             tbl_express,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [NB-1:0]    req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             miss_valid,
  output logic             fn_rd_en,
  output logic             fn_wr_en,
  output logic [IDX_W-1:0] fn_sel,
  output logic [11:0]      fn_off,
  output logic [NB-1:0]    fn_be,
  output logic [DW-1:0]    fn_wdata,
  input  logic [DW-1:0]    fn_rdata
);

  localparam logic [AW-1:0] SIZE_MIN = AW'(1) << MIN_LOG2;
  localparam logic [AW-1:0] SIZE_MAX = AW'(1) << MAX_LOG2;

  logic [AW-1:0] base_q, mask_q;
  logic          size_ok, align_ok, legal;

  assign size_ok  = (ctl_size != '0) && ((ctl_size & (ctl_size - 1'b1)) == '0) &&
                    (ctl_size >= SIZE_MIN) && (ctl_size <= SIZE_MAX);
  assign align_ok = (ctl_base & (ctl_size - 1'b1)) == '0;
  assign legal    = size_ok && align_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_mapped <= 1'b0;
      ctl_reject <= 1'b0;
      base_q     <= '0;
      mask_q     <= '0;
    end else begin
      ctl_reject <= ctl_update && ctl_enable && !legal;
      if (ctl_update) begin
        win_mapped <= ctl_enable && legal;
        base_q     <= ctl_base;
        mask_q     <= ctl_size - 1'b1;
      end
    end
  end

  logic [NUM_FN-1:0] t_v, t_x;
  logic [TAG_W-1:0]  t_tag [NUM_FN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v <= '0;
      t_x <= '0;
      for (int i = 0; i < NUM_FN; i++) t_tag[i] <= '0;
    end else if (tbl_wr) begin
      t_v[tbl_idx]   <= tbl_valid;
      t_x[tbl_idx]   <= tbl_express;
      t_tag[tbl_idx] <= tbl_tag;
    end
  end

  logic             hit, found, xp, in_range, route;
  logic [AW-1:0]    offs;
  logic [TAG_W-1:0] key;
  logic [IDX_W-1:0] sel;

  assign hit  = win_mapped && ((req_addr & ~mask_q) == base_q);
  assign offs = req_addr & mask_q;
  assign key  = {offs[20 +: BUS_W], offs[19:12]};

  always_comb begin
    found = 1'b0;
    sel   = '0;
    xp    = 1'b0;
    for (int i = NUM_FN - 1; i >= 0; i--) begin
      if (t_v[i] && (t_tag[i] == key)) begin
        found = 1'b1;
        sel   = IDX_W'(i);
        xp    = t_x[i];
      end
    end
  end

  assign in_range = xp || (offs[11:8] == 4'h0);
  assign route    = req_valid && hit && found && in_range;
  assign fn_rd_en = route && !req_write;
  assign fn_wr_en = route && req_write;
  assign fn_sel   = sel;
  assign fn_off   = {offs[11:2], 2'b00};
  assign fn_be    = req_be;
  assign fn_wdata = req_wdata;

  logic [DW-1:0] rd_merge;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign rd_merge[8*b +: 8] = req_be[b] ? fn_rdata[8*b +: 8] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      miss_valid <= 1'b0;
      rsp_rdata  <= '1;
    end else begin
      rsp_valid  <= req_valid && hit;
      miss_valid <= req_valid && !hit;
      rsp_rdata  <= fn_rd_en ? rd_merge : '1;
    end
  end

  // R1, R2: while unmapped every request misses
  a_r1_unmapped_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_mapped && !ctl_update) |=> (miss_valid && !rsp_valid));

  // R3: a rejected update never leaves the window mapped
  a_r3_reject_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reject |-> !win_mapped);

  // R3: a mapped window is always aligned to its size
  a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    win_mapped |-> ((base_q & mask_q) == '0));

  // R10: exactly one answer per request, none without one
  a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($countones({rsp_valid, miss_valid}) == 1));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_valid || miss_valid));

  // R7, R8: function strobes only for a request that decoded in the window
  a_r7_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_rd_en || fn_wr_en) |-> (req_valid && win_mapped));

  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fn_rd_en, fn_wr_en}));

endmodule

// File: tb/test_cfg_window_decoder.sv
module test_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_update = 0, ctl_enable = 0;
  logic [31:0] ctl_base = 0, ctl_size = 0;
  logic        win_mapped, ctl_reject;
  logic        tbl_wr = 0, tbl_valid = 0, tbl_express = 0;
  logic [2:0]  tbl_idx = 0;
  logic [16:0] tbl_tag = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic        rsp_valid, miss_valid, fn_rd_en, fn_wr_en;
  logic [31:0] rsp_rdata, fn_wdata, fn_rdata;
  logic [2:0]  fn_sel;
  logic [11:0] fn_off;
  logic [3:0]  fn_be;

  always #10 clk = ~clk;

  cfg_window_decoder i_cfg_window_decoder (.*);

  logic [31:0] fmem [0:7][0:63];
  logic [31:0] smem [0:7][0:63];
  assign fn_rdata = fmem[fn_sel][fn_off[7:2]];
  always @(posedge clk)
    if (fn_wr_en)
      for (int b = 0; b < 4; b++)
        if (fn_be[b]) fmem[fn_sel][fn_off[7:2]][8*b +: 8] <= fn_wdata[8*b +: 8];

  int checks = 0, failures = 0;
  bit done = 0;

  bit          e_mapped = 0;
  logic [31:0] e_base = 0, e_size = 0;
  bit          e_tv [0:7];
  bit          e_tx [0:7];
  logic [16:0] e_tag [0:7];

  bit          q_miss [$];
  logic [31:0] q_data [$];
  bit          q_chk  [$];
  string       q_req  [$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] tag_of(int bus, int dev, int fn);
    return {9'(bus), 5'(dev), 3'(fn)};
  endfunction

  task automatic tbl_set(int idx, bit v, logic [16:0] tag, bit x);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = 3'(idx); tbl_valid = v; tbl_tag = tag; tbl_express = x;
    @(negedge clk);
    tbl_wr = 0;
    e_tv[idx] = v; e_tag[idx] = tag; e_tx[idx] = x;
  endtask

  task automatic ctl_prog(logic [31:0] base, logic [31:0] size, bit en, string req);
    bit legal;
    legal = (size != 0) && ((size & (size - 1)) == 0) && size >= 32'h0010_0000 &&
            size <= 32'h1000_0000 && ((base & (size - 1)) == 0);
    @(negedge clk);
    ctl_update = 1; ctl_enable = en; ctl_base = base; ctl_size = size;
    @(negedge clk);
    ctl_update = 0;
    e_mapped = en && legal; e_base = base; e_size = size;
    chk(win_mapped == e_mapped, {req, " mapped"}, 32'(win_mapped), 32'(e_mapped));
    chk(ctl_reject == (en && !legal), {req, " reject"}, 32'(ctl_reject), 32'(en && !legal));
  endtask

  task automatic access(bit wr, logic [31:0] addr, logic [3:0] be, logic [31:0] wd, string req);
    logic [63:0] lo;
    logic [31:0] off, exp_d;
    bit hit, found, inr, route;
    int sel;
    logic [16:0] key;
    lo  = {32'h0, addr} - {32'h0, e_base};
    hit = e_mapped && addr >= e_base && lo < {32'h0, e_size};
    off = addr - e_base;
    key = {off[28:20], off[19:12]};
    found = 0; sel = 0;
    for (int i = 7; i >= 0; i--)
      if (e_tv[i] && e_tag[i] == key) begin found = 1; sel = i; end
    inr   = found && (e_tx[sel] || off[11:0] < 12'h100);
    route = hit && found && inr;
    exp_d = 32'hFFFF_FFFF;
    if (route && !wr)
      for (int b = 0; b < 4; b++)
        if (be[b]) exp_d[8*b +: 8] = smem[sel][off[7:2]][8*b +: 8];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    #1;
    chk(fn_wr_en == (wr && route), {req, " fn_wr_en"}, 32'(fn_wr_en), 32'(wr && route));
    chk(fn_rd_en == (!wr && route), {req, " fn_rd_en"}, 32'(fn_rd_en), 32'(!wr && route));
    if (route) begin
      chk(fn_sel == 3'(sel), {req, " fn_sel"}, 32'(fn_sel), 32'(sel));
      chk(fn_off == {off[11:2], 2'b00}, {req, " fn_off"}, 32'(fn_off), 32'({off[11:2], 2'b00}));
    end
    if (route && wr)
      for (int b = 0; b < 4; b++)
        if (be[b]) smem[sel][off[7:2]][8*b +: 8] = wd[8*b +: 8];
    q_miss.push_back(!hit); q_data.push_back(exp_d);
    q_chk.push_back(!wr || !hit); q_req.push_back(req);
    @(negedge clk);
    req_valid = 0;
    #2;
    chk(q_miss.size() == 0, "R10 one-cycle answer", 32'(q_miss.size()), 0);
    q_miss.delete(); q_data.delete(); q_chk.delete(); q_req.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && (rsp_valid || miss_valid)) begin
      if (q_miss.size() == 0) chk(0, "R10 unexpected answer", {rsp_valid, miss_valid}, 0);
      else begin
        bit m; logic [31:0] d; bit c; string r;
        m = q_miss.pop_front(); d = q_data.pop_front(); c = q_chk.pop_front(); r = q_req.pop_front();
        chk(miss_valid == m && rsp_valid == !m, {r, " answer kind"}, {rsp_valid, miss_valid}, {!m, m});
        if (c && !m) chk(rsp_rdata == d, {r, " rdata"}, rsp_rdata, d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      e_tv[i] = 0; e_tx[i] = 0; e_tag[i] = 0;
      for (int j = 0; j < 64; j++) begin
        fmem[i][j] = 32'hA000_0000 | (i << 8) | j;
        smem[i][j] = 32'hA000_0000 | (i << 8) | j;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(win_mapped == 0 && rsp_valid == 0 && miss_valid == 0, "R1 reset state",
        {win_mapped, rsp_valid, miss_valid}, 0);
    access(0, 32'hE000_0000, 4'hF, 0, "R1 unmapped read");

    tbl_set(0, 1, tag_of(0, 0, 0), 1);
    tbl_set(1, 1, tag_of(1, 3, 2), 0);
    tbl_set(2, 1, tag_of(5, 31, 7), 1);
    tbl_set(3, 1, tag_of(2, 1, 0), 1);
    tbl_set(4, 1, tag_of(2, 1, 0), 0);

    ctl_prog(32'hE000_0000, 32'h1000_0000, 1, "R3 legal 256MiB");
    access(0, 32'hE000_0000, 4'hF, 0, "R4 R5 read entry0");
    access(1, 32'hE011_A010, 4'hF, 32'h1234_5678, "R6 write entry1");
    access(0, 32'hE011_A010, 4'hF, 0, "R6 readback entry1");
    access(1, 32'hE000_0020, 4'h3, 32'hDEAD_BEEF, "R9 partial write");
    access(0, 32'hE000_0020, 4'hF, 0, "R9 merged readback");
    access(0, 32'hE000_0020, 4'h4, 0, "R9 read lane mask");
    access(0, 32'hE070_0000, 4'hF, 0, "R7 missing read");
    access(1, 32'hE070_0000, 4'hF, 32'h5555_5555, "R7 missing write");
    access(0, 32'hE011_A100, 4'hF, 0, "R8 conv over-limit read");
    access(1, 32'hE011_A100, 4'hF, 32'h0BAD_0BAD, "R8 conv over-limit write");
    access(0, 32'hE011_A000, 4'hF, 0, "R8 alias unchanged");
    access(0, 32'hE05F_FFFC, 4'hF, 0, "R8 express top offset");
    access(0, 32'hE020_8200, 4'hF, 0, "R6 lowest index wins");
    access(0, 32'hD000_0000, 4'hF, 0, "R4 below window");
    access(0, 32'hF000_0000, 4'hF, 0, "R4 at base+size");
    access(0, 32'hEFFF_FFFC, 4'hF, 0, "R4 last dword");

    ctl_prog(32'h4000_0000, 32'h0010_0000, 1, "R2 relocate 1MiB");
    access(0, 32'hE000_0000, 4'hF, 0, "R2 old base misses");
    access(0, 32'h4000_0010, 4'hF, 0, "R5 small window bus0");
    access(0, 32'h4010_0000, 4'hF, 0, "R4 past 1MiB");

    ctl_prog(32'h4000_0000, 32'h0030_0000, 1, "R3 non-pow2 size");
    access(0, 32'h4000_0010, 4'hF, 0, "R3 rejected unmapped");
    ctl_prog(32'h0000_0000, 32'h2000_0000, 1, "R3 size too big");
    ctl_prog(32'h4000_0000, 32'h0008_0000, 1, "R3 size too small");
    ctl_prog(32'h4008_0000, 32'h0010_0000, 1, "R3 misaligned base");
    ctl_prog(32'h4000_0000, 32'h0010_0000, 0, "R2 disable");
    access(0, 32'h4000_0010, 4'hF, 0, "R2 disabled misses");

    ctl_prog(32'h0000_0000, 32'h1000_0000, 1, "R3 base zero");
    access(0, 32'h005F_F004, 4'hF, 0, "R5 bus5 dev31 fn7");
    tbl_set(1, 0, tag_of(1, 3, 2), 0);
    access(0, 32'h0011_A010, 4'hF, 0, "R7 invalidated entry");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule